// File: doc/BRIEF.md
# Boundary-Scan Test Port with Live Status Capture

This block is the test access port controller of a configuration memory device. A four-wire serial test port (test clock, mode select, serial in, serial out) drives a 16-state controller. Through it, a host loads a 16-bit instruction and then shifts one of four data registers. The registers are a 1-bit bypass stage, a 32-bit device identity word, a 32-bit user code word and a boundary chain of parameterized length.

The instruction capture value is not a fixed constant. Every instruction scan first loads the device's live status into the instruction register and shifts it out. That status covers the outcome of the last in-system configuration step, the outcome of the last erase/program step, an erase/program busy flag, the configuration-mode flag and a revision-complete flag. Decoded instructions drive the pin-control outputs: a float-all request and an enable that drives pins from the boundary chain. One vendor instruction sends a single active-low pulse to the configuration pin, together with a revision-reload strobe. A host may pause a long shift by stopping the test clock while the controller stays in a shift state.

Top module: `jtag_cfg_tap`

## Requirements
- R1: The controller follows the standard 16-state test port graph and moves on the rising test-clock edge. Five consecutive rising edges with mode select high reach the reset state from any state. Sampling `trst_n` low on a rising edge also forces the reset state.
- R2: The reset state makes the identity instruction active. A data scan then shifts out the 32-bit identity word, least significant bit first.
- R3: Capture-IR loads the following pattern:
  - bits 15..9 are 0;
  - bits 8..7 are 2'b10 when `isc_ok` is 1 and 2'b01 when it is 0;
  - bits 6..5 follow the same rule from `prog_ok`;
  - bit 4 is the inverse of `prog_busy`;
  - bit 3 is `isc_mode`;
  - bit 2 is `rev_done`;
  - bits 1..0 are 2'b01.
- R4: The instruction register shifts in from `tdi` and out, least significant bit first. The shifted value becomes active in Update-IR. Opcodes are: bypass 16'hFFFF, sample/preload 16'h0001, extest 16'h0000, clamp 16'h00FA, float-all 16'h00FC, identity 16'h00FE, user code 16'h00FD, configure 16'h00EE. Any other opcode acts as bypass. The bypass stage is one bit long and captures 0.
- R5: The user code instruction selects a 32-bit register that reloads `USER_VALUE` in every Capture-DR.
- R6: Sample/preload and extest select the boundary chain. It captures `pins_in` in Capture-DR, and in Update-DR the shifted value moves to `bsr_out`. `bsr_drive` is 1 only under extest or clamp.
- R7: The float-all instruction sets `pins_hiz` to 1 and `bsr_drive` to 0. The clamp instruction sets `bsr_drive` to 1 and leaves `bsr_out` unchanged. Both select the 1-bit bypass stage.
- R8: Entering Run-Test/Idle with the configure instruction active drives `cfg_n` low, and `rev_reload` high, for exactly one test-clock period. Later entries do not repeat the pulse until the instruction is loaded again.
- R9: `tdo` and `tdo_en` change on the falling test-clock edge. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.
- R10: Stopping the test clock during Shift-IR or Shift-DR loses no shift-register content. The scan resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset, sampled on the test clock |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| isc_ok | input | 1 | Last in-system configuration step succeeded |
| prog_ok | input | 1 | Last erase/program step succeeded |
| prog_busy | input | 1 | Erase/program in progress |
| isc_mode | input | 1 | Device in in-system configuration mode |
| rev_done | input | 1 | Selected revision fully programmed |
| pins_in | input | BSR_LEN | Pin values seen by the boundary chain |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Serial output enable |
| bsr_out | output | BSR_LEN | Boundary values for the pin drivers |
| bsr_drive | output | 1 | Drive pins from `bsr_out` |
| pins_hiz | output | 1 | Float all controlled pins |
| cfg_n | output | 1 | Active-low configuration pulse |
| rev_reload | output | 1 | Revision reload strobe |

## Verification
The bench builds the block with a 12-bit boundary chain. Because the chain is neither 1 nor 32 bits, a mistake in the selected length shows up at the ports. The identity and user code values are distinct and irregular, so any swapped selection or misordered bit changes the words shifted out. The bench randomizes the five status inputs across repeated instruction scans, so each field of the capture pattern is checked in both polarities. A directed scan stops the clock in the middle of a shift, and repeated loads of the configure instruction check the one-shot pulse.

// File: rtl/jtag_cfg_pkg.sv
// Shared types for the test port: controller states, opcodes, decoded
// instructions and data-register selection. Assumes a 16-bit instruction.
package jtag_cfg_pkg;

    localparam int IR_W = 16;

    typedef enum logic [3:0] {
        TS_TLR, TS_RTI, TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR,
        TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        INS_BYPASS, INS_SAMPLE, INS_EXTEST, INS_CLAMP,
        INS_HIGHZ, INS_IDCODE, INS_USER, INS_CONFIG
    } ins_t;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_USER, DR_BOUND} dr_sel_t;

    localparam logic [IR_W-1:0] OP_BYPASS = 16'hFFFF;
    localparam logic [IR_W-1:0] OP_SAMPLE = 16'h0001;
    localparam logic [IR_W-1:0] OP_EXTEST = 16'h0000;
    localparam logic [IR_W-1:0] OP_CLAMP  = 16'h00FA;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 16'h00FC;
    localparam logic [IR_W-1:0] OP_IDCODE = 16'h00FE;
    localparam logic [IR_W-1:0] OP_USER   = 16'h00FD;
    localparam logic [IR_W-1:0] OP_CONFIG = 16'h00EE;

    // Map a shifted opcode to an instruction; unknown codes fall to bypass.
    function automatic ins_t decode_op(input logic [IR_W-1:0] op);
        case (op)
            OP_SAMPLE: return INS_SAMPLE;
            OP_EXTEST: return INS_EXTEST;
            OP_CLAMP:  return INS_CLAMP;
            OP_HIGHZ:  return INS_HIGHZ;
            OP_IDCODE: return INS_IDCODE;
            OP_USER:   return INS_USER;
            OP_CONFIG: return INS_CONFIG;
            default:   return INS_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
// 16-state test port controller. Advances on the rising test clock;
// assumes trst_n is sampled synchronously on that edge.
module jtag_tap_fsm
    import jtag_cfg_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t next_state
);

    // Next-state graph of the standard controller.
    always_comb begin
        case (state)
            TS_TLR:    next_state = tms ? TS_TLR    : TS_RTI;
            TS_RTI:    next_state = tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_DR: next_state = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: next_state = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: next_state = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: next_state = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: next_state = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: next_state = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: next_state = tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_IR: next_state = tms ? TS_TLR    : TS_CAP_IR;
            TS_CAP_IR: next_state = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: next_state = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: next_state = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: next_state = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: next_state = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: next_state = tms ? TS_SEL_DR : TS_RTI;
            default:   next_state = TS_TLR;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TS_TLR;
        else         state <= next_state;
    end

    // R1: five high mode-select edges land in the reset state
    p_five_tms_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == TS_TLR);

endmodule

// File: rtl/jtag_ir_unit.sv
// Instruction register: captures live status, shifts LSB first and latches
// the decoded instruction on the falling edge in Update-IR. Assumes the
// status inputs are stable around the capture edge.
module jtag_ir_unit
    import jtag_cfg_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  logic       isc_ok,
    input  logic       prog_ok,
    input  logic       prog_busy,
    input  logic       isc_mode,
    input  logic       rev_done,
    output logic       ir_lsb,
    output ins_t       active
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] status_word;

    // Assemble the status pattern from live inputs.
    always_comb begin
        status_word        = '0;
        status_word[8:7]   = isc_ok  ? 2'b10 : 2'b01;
        status_word[6:5]   = prog_ok ? 2'b10 : 2'b01;
        status_word[4]     = ~prog_busy;
        status_word[3]     = isc_mode;
        status_word[2]     = rev_done;
        status_word[1:0]   = 2'b01;
    end

    // Capture and shift on the rising edge.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= '0;
        else if (state == TS_CAP_IR) ir_sr <= status_word;
        else if (state == TS_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: identity in reset, new code in Update-IR.
    always_ff @(negedge tck) begin
        if (!trst_n || state == TS_TLR) active <= INS_IDCODE;
        else if (state == TS_UPD_IR)    active <= decode_op(ir_sr);
    end

    assign ir_lsb = ir_sr[0];

    // R3: capture loads the fixed fields and the sampled status
    p_capture_fields_r3: assert property (@(posedge tck) disable iff (!trst_n)
        state == TS_CAP_IR |=> (ir_sr[15:9] == 7'd0 && ir_sr[1:0] == 2'b01
            && ir_sr[4] == !$past(prog_busy) && ir_sr[3] == $past(isc_mode)
            && ir_sr[8] == $past(isc_ok) && ir_sr[6] == $past(prog_ok)));

    // R2: the reset state leaves the identity instruction active
    p_reset_ident_r2: assert property (@(negedge tck) disable iff (!trst_n)
        state == TS_TLR |=> active == INS_IDCODE);

endmodule

// File: rtl/jtag_dr_unit.sv
// Data registers: 1-bit bypass, identity word, user code word and boundary
// chain, sharing one shift register whose serial-in position follows the
// selected length. Assumes BSR_LEN >= 1.
module jtag_dr_unit
    import jtag_cfg_pkg::*;
#(
    parameter int          BSR_LEN    = 8,
    parameter logic [31:0] ID_VALUE   = 32'h1A5C_3093,
    parameter logic [31:0] USER_VALUE = 32'h0000_0000
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_t         state,
    input  ins_t               active,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_out
);

    localparam int DR_W  = (BSR_LEN > 32) ? BSR_LEN : 32;
    localparam int IDX_W = $clog2(DR_W);

    dr_sel_t           sel;
    logic [DR_W-1:0]   dr_sr;
    logic [IDX_W-1:0]  top_idx;

    // Pick the register the active instruction connects.
    always_comb begin
        case (active)
            INS_IDCODE:             sel = DR_IDENT;
            INS_USER:               sel = DR_USER;
            INS_SAMPLE, INS_EXTEST: sel = DR_BOUND;
            default:                sel = DR_BYPASS;
        endcase
    end

    // Serial-in bit position for the selected length.
    always_comb begin
        case (sel)
            DR_IDENT, DR_USER: top_idx = IDX_W'(31);
            DR_BOUND:          top_idx = IDX_W'(BSR_LEN - 1);
            default:           top_idx = '0;
        endcase
    end

    // Capture and shift on the rising edge.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            dr_sr <= '0;
        end else if (state == TS_CAP_DR) begin
            dr_sr <= '0;
            case (sel)
                DR_IDENT: dr_sr[31:0]         <= ID_VALUE;
                DR_USER:  dr_sr[31:0]         <= USER_VALUE;
                DR_BOUND: dr_sr[BSR_LEN-1:0]  <= pins_in;
                default:  ;
            endcase
        end else if (state == TS_SHF_DR) begin
            dr_sr          <= {1'b0, dr_sr[DR_W-1:1]};
            dr_sr[top_idx] <= tdi;
        end
    end

    // Boundary update register, loaded on the falling edge in Update-DR.
    always_ff @(negedge tck) begin
        if (!trst_n)                                  bsr_out <= '0;
        else if (state == TS_UPD_DR && sel == DR_BOUND) bsr_out <= dr_sr[BSR_LEN-1:0];
    end

    assign dr_lsb = dr_sr[0];

    // R4: the bypass stage captures zero
    p_bypass_zero_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_CAP_DR && sel == DR_BYPASS) |=> dr_sr[0] == 1'b0);

endmodule

// File: rtl/jtag_cfg_tap.sv
// Top of the test port: controller, instruction and data registers,
// falling-edge serial output and the one-shot configuration pulse.
// Assumes a free-running or host-stopped test clock; all resets synchronous.
module jtag_cfg_tap
    import jtag_cfg_pkg::*;
#(
    parameter int          BSR_LEN    = 8,
    parameter logic [31:0] ID_VALUE   = 32'h1A5C_3093,
    parameter logic [31:0] USER_VALUE = 32'h0000_0000
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic               isc_ok,
    input  logic               prog_ok,
    input  logic               prog_busy,
    input  logic               isc_mode,
    input  logic               rev_done,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               bsr_drive,
    output logic               pins_hiz,
    output logic               cfg_n,
    output logic               rev_reload
);

    tap_state_t state;
    tap_state_t next_state;
    ins_t       active;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       cfg_armed;
    logic       cfg_fire;

    jtag_tap_fsm u_fsm (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .state      (state),
        .next_state (next_state)
    );

    jtag_ir_unit u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .isc_ok    (isc_ok),
        .prog_ok   (prog_ok),
        .prog_busy (prog_busy),
        .isc_mode  (isc_mode),
        .rev_done  (rev_done),
        .ir_lsb    (ir_lsb),
        .active    (active)
    );

    jtag_dr_unit #(
        .BSR_LEN    (BSR_LEN),
        .ID_VALUE   (ID_VALUE),
        .USER_VALUE (USER_VALUE)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .active  (active),
        .pins_in (pins_in),
        .dr_lsb  (dr_lsb),
        .bsr_out (bsr_out)
    );

    // Serial output and its enable, updated on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == TS_SHF_IR) || (state == TS_SHF_DR);
            tdo    <= (state == TS_SHF_IR) ? ir_lsb : dr_lsb;
        end
    end

    // Pin-control decode from the active instruction.
    assign pins_hiz  = (active == INS_HIGHZ);
    assign bsr_drive = (active == INS_EXTEST) || (active == INS_CLAMP);

    // Fire once on entry to Run-Test/Idle after a fresh configure load.
    assign cfg_fire = (next_state == TS_RTI) && (state != TS_RTI) && (active == INS_CONFIG)
                      && (cfg_armed || state == TS_UPD_IR);

    // Pulse register and re-arm flag for the configure instruction.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            cfg_n      <= 1'b1;
            rev_reload <= 1'b0;
            cfg_armed  <= 1'b0;
        end else begin
            cfg_n      <= !cfg_fire;
            rev_reload <= cfg_fire;
            if (cfg_fire)                                          cfg_armed <= 1'b0;
            else if (state == TS_UPD_IR && active == INS_CONFIG)   cfg_armed <= 1'b1;
            else if (state == TS_TLR)                              cfg_armed <= 1'b0;
        end
    end

    // R8: the configuration pulse lasts a single period
    p_cfg_one_cycle_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !cfg_n |=> cfg_n);

    // R8: the pulse only appears while idling
    p_cfg_in_idle_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !cfg_n |-> state == TS_RTI);

    // R9: the output enable is seen only in shift states
    p_tdo_en_shift_r9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == TS_SHF_IR || state == TS_SHF_DR));

endmodule

// File: tb/jtag_cfg_tap_bench.sv
module jtag_cfg_tap_bench;

    localparam int          BL  = 12;
    localparam logic [31:0] IDV = 32'h5B3C_E0A7;
    localparam logic [31:0] USV = 32'hC0DE_4F19;

    logic          tck = 1'b0;
    logic          tck_run = 1'b1;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          isc_ok = 1'b0, prog_ok = 1'b0, prog_busy = 1'b0, isc_mode = 1'b0, rev_done = 1'b0;
    logic [BL-1:0] pins_in = '0;
    logic          tdo, tdo_en, bsr_drive, pins_hiz, cfg_n, rev_reload;
    logic [BL-1:0] bsr_out;

    int n_chk = 0;
    int n_bad = 0;
    int cfg_low_cnt = 0;
    bit done = 0;

    jtag_cfg_tap #(.BSR_LEN(BL), .ID_VALUE(IDV), .USER_VALUE(USV)) u_jtag_cfg_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .isc_ok(isc_ok), .prog_ok(prog_ok), .prog_busy(prog_busy),
        .isc_mode(isc_mode), .rev_done(rev_done), .pins_in(pins_in),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_out(bsr_out), .bsr_drive(bsr_drive),
        .pins_hiz(pins_hiz), .cfg_n(cfg_n), .rev_reload(rev_reload)
    );

    // 100 MHz test clock that the bench can stop
    always begin
        #5;
        if (tck_run) tck = ~tck;
    end

    always @(negedge tck) if (trst_n && !cfg_n) cfg_low_cnt++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample tdo for the coming edge, then drive tms/tdi
    task automatic step(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck);
        #2;
        o = tdo;
        oe = tdo_en;
        tms = m;
        tdi = d;
    endtask

    task automatic idle(input int n);
        logic o, oe;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, o, oe);
    endtask

    task automatic tlr_reset();
        logic o, oe;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
    endtask

    // From Run-Test/Idle: instruction scan, returns to Run-Test/Idle
    task automatic scan_ir(input logic [15:0] op, output logic [15:0] cap);
        logic o, oe;
        step(1'b1, 1'b0, o, oe);
        step(1'b1, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
        for (int i = 0; i < 16; i++) begin
            step(i == 15, op[i], o, oe);
            cap[i] = o;
            if (i == 0) chk(oe == 1'b1, "R9 tdo_en in Shift-IR", 64'(oe), 64'd1);
        end
        step(1'b1, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
    endtask

    // From Run-Test/Idle: data scan of len bits, optional clock stop
    task automatic scan_dr(input int len, input logic [63:0] din, input int pause_at,
                           output logic [63:0] dout);
        logic o, oe;
        dout = '0;
        step(1'b1, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], o, oe);
            dout[i] = o;
            if (i == pause_at) begin
                tck_run = 1'b0;
                #137;
                tck_run = 1'b1;
            end
        end
        step(1'b1, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
    endtask

    function automatic logic [15:0] ir_expect(input logic a, input logic b, input logic bz,
                                              input logic m, input logic r);
        ir_expect = {7'd0, a ? 2'b10 : 2'b01, b ? 2'b10 : 2'b01, ~bz, m, r, 2'b01};
    endfunction

    function automatic bit is_defined(input logic [15:0] op);
        return op == 16'hFFFF || op == 16'h0001 || op == 16'h0000 || op == 16'h00FA
            || op == 16'h00FC || op == 16'h00FE || op == 16'h00FD || op == 16'h00EE;
    endfunction

    initial begin
        logic [15:0] cap, op;
        logic [63:0] dout, din;
        logic [BL-1:0] pv;
        logic o, oe;
        void'($urandom(32'h1D0C_2007));

        idle(3);
        #1;
        chk(cfg_n == 1'b1 && rev_reload == 1'b0, "R8 reset idle pulse", {cfg_n, rev_reload}, 2'b10);
        chk(tdo_en == 1'b0, "R9 reset tdo_en", 64'(tdo_en), 0);
        chk(pins_hiz == 0 && bsr_drive == 0 && bsr_out == 0, "R7 reset pin controls",
            {pins_hiz, bsr_drive, bsr_out}, 0);
        trst_n = 1'b1;
        tms = 1'b0;
        idle(2);

        // R2: identity after reset, LSB first
        scan_dr(32, 0, -1, dout);
        chk(dout[31:0] == IDV, "R2 identity word", dout, 64'(IDV));
        chk(tdo_en == 1'b0, "R9 tdo_en idle", 64'(tdo_en), 0);

        // R3: random status patterns
        for (int k = 0; k < 12; k++) begin
            {isc_ok, prog_ok, prog_busy, isc_mode, rev_done} = 5'($urandom);
            scan_ir(16'hFFFF, cap);
            chk(cap == ir_expect(isc_ok, prog_ok, prog_busy, isc_mode, rev_done),
                "R3 capture pattern", 64'(cap), 64'(ir_expect(isc_ok, prog_ok, prog_busy, isc_mode, rev_done)));
        end

        // R4: bypass one-bit delay, defined and undefined opcodes
        for (int k = 0; k < 6; k++) begin
            op = 16'($urandom);
            if (k == 0) op = 16'hFFFF;
            if (is_defined(op)) op = 16'h1234;
            scan_ir(op, cap);
            din = 64'($urandom);
            scan_dr(9, din, -1, dout);
            chk(dout[8:0] == {din[7:0], 1'b0}, "R4 bypass delay", dout[8:0], {din[7:0], 1'b0});
        end

        // R5: user code
        scan_ir(16'h00FD, cap);
        scan_dr(32, 0, -1, dout);
        chk(dout[31:0] == USV, "R5 user code", dout, 64'(USV));
        scan_dr(32, 64'hFFFF_FFFF, -1, dout);
        chk(dout[31:0] == USV, "R5 user code reload", dout, 64'(USV));

        // R1: five high TMS from mid-shift returns to identity
        step(1'b1, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
        step(1'b0, 1'b0, o, oe);
        step(1'b0, 1'b1, o, oe);
        tlr_reset();
        scan_dr(32, 0, -1, dout);
        chk(dout[31:0] == IDV, "R1 tms reset to identity", dout, 64'(IDV));

        // R1: synchronous trst_n
        scan_ir(16'h00FD, cap);
        trst_n = 1'b0;
        idle(2);
        trst_n = 1'b1;
        idle(1);
        scan_dr(32, 0, -1, dout);
        chk(dout[31:0] == IDV, "R1 trst_n reset", dout, 64'(IDV));

        // R6: sample/preload
        pv = BL'($urandom);
        pins_in = pv;
        scan_ir(16'h0001, cap);
        din = 64'($urandom) & ((64'd1 << BL) - 1);
        scan_dr(BL, din, -1, dout);
        chk(dout[BL-1:0] == pv, "R6 boundary capture", dout, 64'(pv));
        chk(bsr_out == din[BL-1:0] && bsr_drive == 1'b0, "R6 preload update",
            {bsr_drive, bsr_out}, din);

        // R6: extest
        scan_ir(16'h0000, cap);
        chk(bsr_drive == 1'b1 && pins_hiz == 1'b0, "R6 extest drive", {bsr_drive, pins_hiz}, 2'b10);
        pins_in = ~pv;
        scan_dr(BL, ~din, -1, dout);
        chk(dout[BL-1:0] == ~pv, "R6 extest capture", dout, 64'(~pv));
        chk(bsr_out == ~din[BL-1:0], "R6 extest update", bsr_out, 64'(~din[BL-1:0]));

        // R7: clamp keeps boundary values and uses bypass
        scan_ir(16'h00FA, cap);
        scan_dr(3, 64'b101, -1, dout);
        chk(dout[2:0] == 3'b010, "R7 clamp bypass", dout[2:0], 3'b010);
        chk(bsr_drive == 1'b1 && bsr_out == ~din[BL-1:0], "R7 clamp hold",
            {bsr_drive, bsr_out}, {1'b1, ~din[BL-1:0]});

        // R7: float-all
        scan_ir(16'h00FC, cap);
        scan_dr(3, 64'b011, -1, dout);
        chk(dout[2:0] == 3'b110, "R7 highz bypass", dout[2:0], 3'b110);
        chk(pins_hiz == 1'b1 && bsr_drive == 1'b0, "R7 highz controls", {pins_hiz, bsr_drive}, 2'b10);

        // R8: configure pulse once per load
        cfg_low_cnt = 0;
        scan_ir(16'h00EE, cap);
        @(negedge tck); #2;
        chk(cfg_n == 1'b0 && rev_reload == 1'b1, "R8 pulse start", {cfg_n, rev_reload}, 2'b01);
        @(negedge tck); #2;
        chk(cfg_n == 1'b1 && rev_reload == 1'b0, "R8 pulse end", {cfg_n, rev_reload}, 2'b10);
        idle(3);
        scan_dr(4, 0, -1, dout);
        idle(2);
        chk(cfg_low_cnt == 1, "R8 single pulse", cfg_low_cnt, 1);
        scan_ir(16'h00EE, cap);
        idle(3);
        chk(cfg_low_cnt == 2, "R8 pulse on reload", cfg_low_cnt, 2);

        // R10: stop the clock mid-shift
        scan_ir(16'h00FE, cap);
        scan_dr(32, 0, 13, dout);
        chk(dout[31:0] == IDV, "R10 paused shift", dout, 64'(IDV));
        scan_ir(16'h00FD, cap);
        scan_dr(32, 0, 5, dout);
        chk(dout[31:0] == USV, "R10 paused user shift", dout, 64'(USV));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is one failed check
    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule